// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This combinational unit produces the second operand of a 32-bit data-processing operation, together with the carry that a logical operation commits to the carry flag. It accepts one of two operand forms. The immediate form takes an 8-bit constant and rotates it right by an even amount. The register form takes a register value and shifts it left, logically right, arithmetically right or rotates it right. The shift amount comes either from a 5-bit field in the operation word or from the low byte of a second register. The current carry flag is an input, because several encodings pass it through unchanged and rotate-through-carry shifts it into the result.

An amount of zero encoded in the immediate 5-bit field has special meanings. For a logical or arithmetic right shift it stands for a shift of 32, and for a rotate it selects a one-bit rotate through the carry. Register-specified amounts follow separate rules for an amount of zero, of exactly 32, and of more than 32. An index mode, used for load/store address offsets, forces the register form with an immediate amount whatever the other selectors say. The ALU and the commit of flags are outside this block.

Top module: `opsh_unit`

## Requirements
- R1: When `imm_form` is 1 and `index_mode` is 0, `shifted` is the zero-extended constant `op_field[7:0]` rotated right by twice the value of `op_field[11:8]`.
- R2: In the immediate form, `carry_out` equals `carry_in` when `op_field[11:8]` is 0, and otherwise equals bit 31 of `shifted`.
- R3: In the register form, `op_field[6:5]` selects the shift type (0 left, 1 logical right, 2 arithmetic right, 3 rotate right). `op_field[4]` = 1 takes the amount from `rs_low`, and 0 takes it from `op_field[11:7]`. For any type with an amount from 1 to 31, `carry_out` is the last bit shifted out (for a rotate, the bit that lands in bit 31).
- R4: A left shift with an immediate amount of 0 passes `rm_val` through, with `carry_out` = `carry_in`. A logical right shift with an immediate amount of 0 acts as a shift of 32: the result is 0 and `carry_out` = `rm_val[31]`. An arithmetic right shift with an immediate amount of 0 acts as a shift of 32: every result bit and `carry_out` equal `rm_val[31]`.
- R5: A rotate with an immediate amount of 0 gives `{carry_in, rm_val[31:1]}`, with `carry_out` = `rm_val[0]`.
- R6: A register-specified amount of 0 in `rs_low` passes `rm_val` through for every shift type, with `carry_out` = `carry_in`.
- R7: A register-specified left or logical right shift by exactly 32 gives 0, with `carry_out` = `rm_val[0]` (left) or `rm_val[31]` (right). For more than 32, both the result and `carry_out` are 0.
- R8: A register-specified arithmetic right shift of 32 or more fills every result bit with `rm_val[31]`, and `carry_out` = `rm_val[31]`.
- R9: A register-specified rotate uses the amount modulo 32. A nonzero multiple of 32 leaves `rm_val` unchanged, with `carry_out` = `rm_val[31]`.
- R10: With `index_mode` = 1, `imm_form` and `op_field[4]` are ignored, and the result is the register form with the amount taken from `op_field[11:7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_form | input | 1 | 1 selects the rotated-constant form |
| index_mode | input | 1 | 1 selects load/store offset behaviour (immediate amounts only) |
| op_field | input | 12 | Low 12 bits of the operation word: constant and rotate, or amount, type and amount source |
| rm_val | input | 32 | Register value to be shifted |
| rs_low | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| shifted | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench targets the amount boundaries where a shifter built from a plain barrel shift goes wrong: 0, 31, 32, 33 and large register amounts, and rotate amounts that are nonzero multiples of 32. A design that treated an immediate zero literally would return `rm_val` unchanged for a logical right shift instead of 0, or would never move the carry into bit 31 on a rotate. A design that reduced register amounts modulo 32 would give nonzero results for 33-bit logical shifts, and one that read the full amount register would treat 0x100 as a large amount and not as a pass-through. Index mode is driven with the constant selector and the register-amount bit both set, so a design that still honoured either one produces a rotated constant or a register-sized shift.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  parameter int unsigned OPS_DW   = 32;
  localparam int unsigned SH_W    = $clog2(OPS_DW);
  localparam int unsigned ROT_W   = 4;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned AMT_W   = 8;
  localparam int unsigned FIELD_W = IMM_W + ROT_W;

  typedef logic [OPS_DW-1:0] word_t;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shkind_e;

  typedef struct packed {
    shkind_e          kind;
    logic             rrx;
    logic [AMT_W-1:0] amt;
  } shctl_t;

  // Rotate right; r of zero returns v.
  function automatic word_t ror_w(input word_t v, input logic [SH_W-1:0] r);
    return (v >> r) | (v << (OPS_DW - int'(r)));
  endfunction

  // Left shift by 0..OPS_DW, result {carry, value}.
  function automatic logic [OPS_DW:0] lsl_c(input word_t v, input logic [SH_W:0] n);
    logic [OPS_DW:0] t;
    t = {1'b0, v} << n;
    return t;
  endfunction

  // Logical right shift by 0..OPS_DW, result {value, carry}.
  function automatic logic [OPS_DW:0] lsr_c(input word_t v, input logic [SH_W:0] n);
    logic [OPS_DW:0] t;
    t = {v, 1'b0} >> n;
    return t;
  endfunction

  // Arithmetic right shift by 0..OPS_DW, result {value, carry}.
  function automatic logic [OPS_DW:0] asr_c(input word_t v, input logic [SH_W:0] n);
    logic signed [OPS_DW:0] t;
    t = $signed({v, 1'b0}) >>> n;
    return $unsigned(t);
  endfunction
endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
(
  input  logic             index_mode,
  input  logic [11:4]      ctl_bits,
  input  logic [AMT_W-1:0] rs_low,
  output shctl_t           ctl,
  output logic             amt_from_reg
);
  logic [SH_W-1:0] imm_amt;
  shkind_e         kind;

  assign imm_amt      = ctl_bits[11:7];
  assign kind         = shkind_e'(ctl_bits[6:5]);
  assign amt_from_reg = ctl_bits[4] & ~index_mode;

  always_comb begin
    ctl.kind = kind;
    ctl.rrx  = 1'b0;
    ctl.amt  = AMT_W'(imm_amt);
    if (amt_from_reg) begin
      ctl.amt = rs_low;
    end else if (imm_amt == '0) begin
      unique case (kind)
        SK_LSL: ctl.amt = '0;
        SK_LSR,
        SK_ASR: ctl.amt = AMT_W'(OPS_DW);
        SK_ROR: begin
          ctl.amt = '0;
          ctl.rrx = 1'b1;
        end
        default: ctl.amt = '0;
      endcase
    end
  end
endmodule

// File: rtl/opsh_reg_shift.sv
module opsh_reg_shift
  import opsh_pkg::*;
(
  input  shctl_t ctl,
  input  word_t  rm_val,
  input  logic   carry_in,
  output word_t  res,
  output logic   cout
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(OPS_DW);

  logic            amt_zero;
  logic            amt_over;
  logic [SH_W:0]   amt_clip;
  logic [OPS_DW:0] lsl_r;
  logic [OPS_DW:0] lsr_r;
  logic [OPS_DW:0] asr_r;
  word_t           ror_r;

  assign amt_zero = (ctl.amt == '0);
  assign amt_over = (ctl.amt > FULL_AMT);
  assign amt_clip = (ctl.amt >= FULL_AMT) ? (SH_W+1)'(OPS_DW) : ctl.amt[SH_W:0];

  assign lsl_r = lsl_c(rm_val, amt_clip);
  assign lsr_r = lsr_c(rm_val, amt_clip);
  assign asr_r = asr_c(rm_val, amt_clip);
  assign ror_r = ror_w(rm_val, ctl.amt[SH_W-1:0]);

  always_comb begin
    res  = rm_val;
    cout = carry_in;
    if (ctl.rrx) begin
      res  = {carry_in, rm_val[OPS_DW-1:1]};
      cout = rm_val[0];
    end else if (!amt_zero) begin
      unique case (ctl.kind)
        SK_LSL: begin
          res  = amt_over ? '0 : lsl_r[OPS_DW-1:0];
          cout = amt_over ? 1'b0 : lsl_r[OPS_DW];
        end
        SK_LSR: begin
          res  = amt_over ? '0 : lsr_r[OPS_DW:1];
          cout = amt_over ? 1'b0 : lsr_r[0];
        end
        SK_ASR: begin
          res  = asr_r[OPS_DW:1];
          cout = asr_r[0];
        end
        SK_ROR: begin
          res  = ror_r;
          cout = ror_r[OPS_DW-1];
        end
        default: begin
          res  = rm_val;
          cout = carry_in;
        end
      endcase
    end
  end
endmodule

// File: rtl/opsh_imm_rot.sv
module opsh_imm_rot
  import opsh_pkg::*;
(
  input  logic [FIELD_W-1:0] const_bits,
  input  logic               carry_in,
  output word_t              res,
  output logic               cout
);
  logic [SH_W-1:0] rot_amt;
  word_t           base;

  assign rot_amt = SH_W'({const_bits[FIELD_W-1:IMM_W], 1'b0});
  assign base    = word_t'(const_bits[IMM_W-1:0]);
  assign res     = ror_w(base, rot_amt);
  assign cout    = (rot_amt == '0) ? carry_in : res[OPS_DW-1];
endmodule

// File: rtl/opsh_unit.sv
module opsh_unit
  import opsh_pkg::*;
(
  input  logic               imm_form,
  input  logic               index_mode,
  input  logic [FIELD_W-1:0] op_field,
  input  logic [OPS_DW-1:0]  rm_val,
  input  logic [AMT_W-1:0]   rs_low,
  input  logic               carry_in,
  output logic [OPS_DW-1:0]  shifted,
  output logic               carry_out
);
  logic   use_imm;
  logic   amt_from_reg;
  shctl_t ctl;
  word_t  imm_res;
  word_t  reg_res;
  logic   imm_c;
  logic   reg_c;

  assign use_imm = imm_form & ~index_mode;

  opsh_decode u_decode (
    .index_mode   (index_mode),
    .ctl_bits     (op_field[11:4]),
    .rs_low       (rs_low),
    .ctl          (ctl),
    .amt_from_reg (amt_from_reg)
  );

  opsh_imm_rot u_imm (
    .const_bits (op_field),
    .carry_in   (carry_in),
    .res        (imm_res),
    .cout       (imm_c)
  );

  opsh_reg_shift u_shift (
    .ctl      (ctl),
    .rm_val   (rm_val),
    .carry_in (carry_in),
    .res      (reg_res),
    .cout     (reg_c)
  );

  assign shifted   = use_imm ? imm_res : reg_res;
  assign carry_out = use_imm ? imm_c   : reg_c;

  // Checks on the ports against the selected behaviour.
  logic    reg_amt_sel;
  logic    imm_amt_sel;
  shkind_e op_kind;
  assign reg_amt_sel = ~use_imm & op_field[4] & ~index_mode;
  assign imm_amt_sel = ~use_imm & (~op_field[4] | index_mode);
  assign op_kind     = shkind_e'(op_field[6:5]);

  always_comb begin
    if (use_imm && op_field[11:8] == '0)
      AST_IMM_NO_ROT: assert (shifted == word_t'(op_field[7:0]) && carry_out == carry_in)
        else $error("constant without rotate altered"); // R2
    if (reg_amt_sel && rs_low == '0)
      AST_REG_ZERO_PASS: assert (shifted == rm_val && carry_out == carry_in)
        else $error("zero register amount not a pass-through"); // R6
    if (reg_amt_sel && (op_kind == SK_LSL || op_kind == SK_LSR) && rs_low > AMT_W'(OPS_DW))
      AST_LOGICAL_WIDE: assert (shifted == '0 && !carry_out)
        else $error("wide logical shift not cleared"); // R7
    if (reg_amt_sel && op_kind == SK_ASR && rs_low >= AMT_W'(OPS_DW))
      AST_ASR_WIDE: assert (shifted == {OPS_DW{rm_val[OPS_DW-1]}} && carry_out == rm_val[OPS_DW-1])
        else $error("wide arithmetic shift not sign filled"); // R8
    if (imm_amt_sel && op_kind == SK_ROR && op_field[11:7] == '0)
      AST_RRX: assert (shifted == {carry_in, rm_val[OPS_DW-1:1]} && carry_out == rm_val[0])
        else $error("rotate through carry wrong"); // R5
  end
endmodule

// File: tb/opsh_unit_tb.sv
`timescale 1ns/1ps
module opsh_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imm_form = 1'b0;
  logic        index_mode = 1'b0;
  logic [11:0] op_field = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_low = '0;
  logic        carry_in = 1'b0;
  logic [31:0] shifted;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opsh_unit u_dut (
    .imm_form   (imm_form),
    .index_mode (index_mode),
    .op_field   (op_field),
    .rm_val     (rm_val),
    .rs_low     (rs_low),
    .carry_in   (carry_in),
    .shifted    (shifted),
    .carry_out  (carry_out)
  );

  // Behavioural model: one bit position per loop step.
  function automatic logic [32:0] model(input logic fi, input logic fx, input logic [11:0] f,
                                        input logic [31:0] a, input logic [7:0] b, input logic ci);
    logic [31:0] v;
    logic        c;
    int          n;
    int          typ;
    bit          from_reg;
    v = a;
    c = ci;
    if (fi && !fx) begin
      v = {24'h0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
      return {c, v};
    end
    typ = int'(f[6:5]);
    from_reg = f[4] && !fx;
    n = from_reg ? int'(b) : int'(f[11:7]);
    if (!from_reg && n == 0) begin
      if (typ == 1 || typ == 2) n = 32;
      else if (typ == 3) return {a[0], ci, a[31:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (typ)
        0: begin c = v[31]; v = v << 1; end
        1: begin c = v[0];  v = v >> 1; end
        2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic run(input logic fi, input logic fx, input logic [11:0] f, input logic [31:0] a,
                     input logic [7:0] b, input logic ci, input string tag);
    logic [32:0] exp_v;
    @(negedge clk);
    imm_form = fi; index_mode = fx; op_field = f; rm_val = a; rs_low = b; carry_in = ci;
    @(posedge clk);
    exp_v = model(fi, fx, f, a, b, ci);
    checks++;
    if (shifted !== exp_v[31:0] || carry_out !== exp_v[32]) begin
      errors++;
      $display("FAIL %s: got out=%08h c=%b expected out=%08h c=%b (field=%03h rm=%08h rs=%02h ci=%b)",
               tag, shifted, carry_out, exp_v[31:0], exp_v[32], f, a, b, ci);
    end
  endtask

  function automatic logic [11:0] fimm(input int rot, input logic [7:0] k);
    return {rot[3:0], k};
  endfunction

  function automatic logic [11:0] freg(input int amt, input int typ, input bit by_reg);
    return {amt[4:0], typ[1:0], by_reg, 4'h0};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Quiescent state: all-zero inputs give a zero operand and zero carry.
    run(1, 0, 12'h000, 32'h0, 8'h0, 0, "R1 reset");
    // R1 constant rotate
    run(1, 0, fimm(4, 8'hFF), 32'h0, 8'h0, 0, "R1");
    run(1, 0, fimm(15, 8'h81), 32'h0, 8'h0, 0, "R1");
    // R2 constant carry
    run(1, 0, fimm(0, 8'h80), 32'h0, 8'h0, 1, "R2");
    run(1, 0, fimm(1, 8'h03), 32'h0, 8'h0, 0, "R2");
    run(1, 0, fimm(2, 8'h01), 32'h0, 8'h0, 1, "R2");
    // R3 amounts 1..31
    run(0, 0, freg(4, 0, 0), 32'hF000_0001, 8'h0, 0, "R3");
    run(0, 0, freg(31, 0, 0), 32'h0000_0003, 8'h0, 0, "R3");
    run(0, 0, freg(3, 1, 0), 32'h0000_0015, 8'h0, 0, "R3");
    run(0, 0, freg(5, 2, 0), 32'h8000_0010, 8'h0, 0, "R3");
    run(0, 0, freg(8, 3, 0), 32'h1234_5680, 8'h0, 0, "R3");
    run(0, 0, freg(0, 1, 1), 32'h8000_0001, 8'd31, 0, "R3");
    // R4 immediate zero amounts
    run(0, 0, freg(0, 0, 0), 32'hDEAD_BEEF, 8'h0, 1, "R4");
    run(0, 0, freg(0, 1, 0), 32'h8000_0000, 8'h0, 0, "R4");
    run(0, 0, freg(0, 2, 0), 32'h8000_0000, 8'h0, 0, "R4");
    run(0, 0, freg(0, 2, 0), 32'h7FFF_FFFF, 8'h0, 1, "R4");
    // R5 rotate through carry
    run(0, 0, freg(0, 3, 0), 32'h0000_0003, 8'h0, 1, "R5");
    run(0, 0, freg(0, 3, 0), 32'h8000_0002, 8'h0, 0, "R5");
    // R6 register amount of zero, upper byte of amount register absent
    run(0, 0, freg(9, 0, 1), 32'hCAFE_0001, 8'h00, 1, "R6");
    run(0, 0, freg(0, 2, 1), 32'h8000_0000, 8'h00, 0, "R6");
    run(0, 0, freg(0, 3, 1), 32'h0000_0001, 8'h00, 1, "R6");
    // R7 register logical 32 and above
    run(0, 0, freg(0, 0, 1), 32'h0000_0001, 8'd32, 0, "R7");
    run(0, 0, freg(0, 1, 1), 32'h8000_0000, 8'd32, 0, "R7");
    run(0, 0, freg(0, 0, 1), 32'hFFFF_FFFF, 8'd33, 1, "R7");
    run(0, 0, freg(0, 1, 1), 32'hFFFF_FFFF, 8'd200, 1, "R7");
    // R8 register arithmetic 32 and above
    run(0, 0, freg(0, 2, 1), 32'h8000_0000, 8'd32, 0, "R8");
    run(0, 0, freg(0, 2, 1), 32'h7FFF_FFFF, 8'd100, 1, "R8");
    run(0, 0, freg(0, 2, 1), 32'hC000_0000, 8'd255, 0, "R8");
    // R9 register rotate modulo 32
    run(0, 0, freg(0, 3, 1), 32'h8000_0001, 8'd32, 0, "R9");
    run(0, 0, freg(0, 3, 1), 32'h7000_0001, 8'd64, 1, "R9");
    run(0, 0, freg(0, 3, 1), 32'h8765_4321, 8'd224, 0, "R9");
    run(0, 0, freg(0, 3, 1), 32'h0000_0018, 8'd36, 0, "R9");
    // R10 index mode ignores the constant selector and the amount source bit
    run(1, 1, freg(4, 0, 0), 32'h0000_00F1, 8'h0, 0, "R10");
    run(0, 1, freg(2, 1, 1), 32'h0000_0F0F, 8'd8, 0, "R10");
    run(1, 1, freg(0, 3, 1), 32'h0000_0001, 8'd40, 1, "R10");
    // Random sweep over all forms
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] rb;
      rb = $urandom_range(0, 3) == 0 ? 8'($urandom_range(30, 66)) : 8'($urandom);
      run(1'($urandom), 1'($urandom_range(0, 5) == 0), 12'($urandom), $urandom, rb,
          1'($urandom), "R3 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule